// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block is the address-recognition front end of an I2C controller working as a target. It holds the device's own address in a 16-bit register, watches the sampled SCL and SDA lines, and follows the address phase that comes after every START or repeated START. When the address on the bus equals the programmed one, it drives the acknowledge slot, raises a sticky match flag, drops the controller's master-role bit, and can raise an interrupt.

The address can be 7 or 10 bits wide, as chosen by a mode input. In 10-bit mode the block answers both address bytes. The level placed in the acknowledge slot on a match comes from a programmable bit, so software can refuse a transfer while still seeing that it was addressed. A byte that does not match makes the block stand back until the next START. A STOP clears the address tracking state.

Top module: `i2c_addr_match`

## Requirements
- R1: The address register read value has bits 15:10 always zero. Writes to those bits have no effect, and bits 9:0 store the written value.
- R2: After reset the register reads 0x0204.
- R3: In 7-bit mode, the first byte after a START matches when its bits 7:1 equal register bits 6:0, whatever the value of its bit 0 (read/write). On a match with the ACK-value input 0, `sda_pd_o` is 1 while SCL is high in the ninth clock.
- R4: In 7-bit mode, register bits 9:7 have no effect on matching.
- R5: In 10-bit mode, the first byte must be binary 11110, then register bits 9:8, then the read/write bit. The second byte must equal register bits 7:0. The acknowledge slot is driven after each matching byte. The match flag is set only after the second byte matches.
- R6: After a byte that does not match, `sda_pd_o` stays 0 for its acknowledge slot and for every later byte until a new START or repeated START.
- R7: While `en_i` is 0, `sda_pd_o` stays 0 and no match is recorded.
- R8: With `ack_val_i` = 1, a match leaves SDA released (`sda_pd_o` = 0) in the acknowledge slot but still sets the match flag.
- R9: A match sets `flag_o` and clears `mst_o`. The flag then stays at 1 through later bus traffic until a `flag_clr_i` pulse clears it. `mst_set_i` sets `mst_o`.
- R10: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R11: A STOP ends address tracking. Bits clocked after a STOP with no new START are never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| en_i | input | 1 | Module enable |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| ack_val_i | input | 1 | Level to place in the acknowledge slot on a match (0 = ACK) |
| irq_en_i | input | 1 | Address-match interrupt enable |
| reg_we_i | input | 1 | Address register write strobe |
| reg_wdata_i | input | 16 | Address register write data |
| flag_clr_i | input | 1 | Clears the match flag |
| mst_set_i | input | 1 | Sets the master-role bit |
| reg_rdata_o | output | 16 | Address register read value |
| sda_pd_o | output | 1 | SDA pull-down request |
| flag_o | output | 1 | Address-match flag |
| irq_o | output | 1 | Interrupt request |
| mst_o | output | 1 | Master-role bit |

## Verification
The assertions assume a well-formed bus: SDA changes only while SCL is low, except at START and STOP, and every SCL phase lasts several clock cycles. They also assume that `en_i` and `ack_val_i` change only between transfers. The check that the pull-down rises only while SCL is low depends on these assumptions. The bench drives every SCL and SDA edge through fixed multi-cycle phase tasks. It changes the enable, mode and ACK-value inputs only while the bus is idle. It models the open-drain line as the master level ANDed with the inverted pull-down.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ACK_HI,
    ST_ADDR2,
    ST_ACK_FIN,
    ST_SKIP
  } am_state_e;
endpackage

// File: rtl/i2c_am_bus_mon.sv
module i2c_am_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges while SCL held high mark bus conditions
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              scl_rise_i,
  input  logic              sda_i,
  output logic              full_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;

  assign full_o = (cnt_q == CNT_FULL);
  assign byte_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i && !full_o) begin
      cnt_q <= cnt_q + 1'b1;
      sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
    end
  end
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LO_W   = 7
) (
  input  logic [ADDR_W-1:0] own_i,
  input  logic [7:0]        byte_i,
  output logic              hit7_o,
  output logic              hit_hi_o,
  output logic              hit_lo_o
);
  import i2c_am_pkg::*;
  localparam int unsigned HI_W = ADDR_W - 8;

  // bit 0 of the first byte is the direction and is never compared
  assign hit7_o   = (byte_i[7:1] == own_i[LO_W-1:0]);
  assign hit_hi_o = (byte_i[7:3] == TEN_PREFIX) && (byte_i[2:1] == own_i[ADDR_W-1:ADDR_W-HI_W]);
  assign hit_lo_o = (byte_i == own_i[7:0]);
endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ten_bit_i,
  input  logic ack_val_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic scl_fall_i,
  input  logic full_i,
  input  logic hit7_i,
  input  logic hit_hi_i,
  input  logic hit_lo_i,
  input  logic flag_clr_i,
  input  logic mst_set_i,
  output logic sh_clr_o,
  output logic sda_pd_o,
  output logic flag_o,
  output logic mst_o
);
  import i2c_am_pkg::*;

  am_state_e state_q, state_d;
  logic      byte_end, set_match, in_ack;
  logic      flag_q, mst_q;

  assign byte_end = full_i & scl_fall_i;

  always_comb begin
    state_d = state_q;
    if (!en_i || stop_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = ST_ADDR1;
    end else begin
      unique case (state_q)
        ST_ADDR1: if (byte_end) begin
          if (ten_bit_i) state_d = hit_hi_i ? ST_ACK_HI : ST_SKIP;
          else           state_d = hit7_i ? ST_ACK_FIN : ST_SKIP;
        end
        ST_ACK_HI:  if (scl_fall_i) state_d = ST_ADDR2;
        ST_ADDR2:   if (byte_end) state_d = hit_lo_i ? ST_ACK_FIN : ST_SKIP;
        ST_ACK_FIN: if (scl_fall_i) state_d = ST_SKIP;
        ST_IDLE, ST_SKIP: state_d = state_q;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  assign set_match = (state_d == ST_ACK_FIN) && (state_q != ST_ACK_FIN);
  assign in_ack    = (state_q == ST_ACK_HI) || (state_q == ST_ACK_FIN);
  assign sh_clr_o  = start_i | ((state_q == ST_ACK_HI) & scl_fall_i);
  assign sda_pd_o  = in_ack & en_i & ~ack_val_i;
  assign flag_o    = flag_q;
  assign mst_o     = mst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
      mst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_match)       flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (set_match)       mst_q <= 1'b0;
      else if (mst_set_i)  mst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned LO_W    = 7,
  parameter logic [9:0]  RST_VAL = 10'h204
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             en_i,
  input  logic             ten_bit_i,
  input  logic             ack_val_i,
  input  logic             irq_en_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             flag_clr_i,
  input  logic             mst_set_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sda_pd_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             mst_o
);
  import i2c_am_pkg::*;
  localparam int unsigned RSV_W = REG_W - ADDR_W;

  logic [ADDR_W-1:0] own_q;
  logic              start, stop, scl_rise, scl_fall;
  logic              sh_clr, full;
  logic [BYTE_W-1:0] byte_v;
  logic              hit7, hit_hi, hit_lo;
  logic              unused_rsv;

  assign unused_rsv = ^reg_wdata_i[REG_W-1:ADDR_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       own_q <= RST_VAL[ADDR_W-1:0];
    else if (reg_we_i) own_q <= reg_wdata_i[ADDR_W-1:0];
  end

  assign reg_rdata_o = {{RSV_W{1'b0}}, own_q};

  i2c_am_bus_mon u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  i2c_am_shifter #(.BYTE_W(BYTE_W)) u_sh (
    .clk_i, .rst_ni, .clr_i(sh_clr), .scl_rise_i(scl_rise), .sda_i,
    .full_o(full), .byte_o(byte_v)
  );

  i2c_am_cmp #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_cmp (
    .own_i(own_q), .byte_i(byte_v),
    .hit7_o(hit7), .hit_hi_o(hit_hi), .hit_lo_o(hit_lo)
  );

  i2c_am_ctrl u_ctrl (
    .clk_i, .rst_ni, .en_i, .ten_bit_i, .ack_val_i,
    .start_i(start), .stop_i(stop), .scl_fall_i(scl_fall), .full_i(full),
    .hit7_i(hit7), .hit_hi_i(hit_hi), .hit_lo_i(hit_lo),
    .flag_clr_i, .mst_set_i,
    .sh_clr_o(sh_clr), .sda_pd_o, .flag_o, .mst_o
  );

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_i,
  input logic        en_i,
  input logic        ack_val_i,
  input logic        irq_en_i,
  input logic        flag_clr_i,
  input logic [15:0] reg_rdata_o,
  input logic        sda_pd_o,
  input logic        flag_o,
  input logic        irq_o,
  input logic        mst_o
);
  AST_RSV_ZERO:    assert property (@(posedge clk_i) disable iff (!rst_ni) reg_rdata_o[15:10] == 6'd0); // R1
  AST_PD_SCL_LOW:  assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(sda_pd_o) |-> !scl_i); // R3
  AST_PD_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni) sda_pd_o |-> en_i); // R7
  AST_PD_ACKVAL:   assert property (@(posedge clk_i) disable iff (!rst_ni) sda_pd_o |-> !ack_val_i); // R8
  AST_MATCH_MST:   assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(flag_o) |-> !mst_o); // R9
  AST_FLAG_HOLD:   assert property (@(posedge clk_i) disable iff (!rst_ni) (flag_o && !flag_clr_i) |=> flag_o); // R9
  AST_IRQ_GATED:   assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> (irq_en_i && flag_o)); // R10
endmodule

bind i2c_addr_match i2c_am_chk u_chk (.*);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic en = 1'b0, ten = 1'b0, ackv = 1'b0, irqen = 1'b0;
  logic we = 1'b0, fclr = 1'b0, mset = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic sda_pd, flag, irq, mst, sda_bus;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pd;

  i2c_addr_match u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .en_i(en), .ten_bit_i(ten), .ack_val_i(ackv), .irq_en_i(irqen),
    .reg_we_i(we), .reg_wdata_i(wdata), .flag_clr_i(fclr), .mst_set_i(mset),
    .reg_rdata_o(rdata), .sda_pd_o(sda_pd), .flag_o(flag), .irq_o(irq), .mst_o(mst)
  );

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [15:0] d);
    wdata = d; we = 1'b1; w(1); we = 1'b0; w(1);
  endtask

  task automatic prep();
    fclr = 1'b1; mset = 1'b1; w(1); fclr = 1'b0; mset = 1'b0; w(1);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(2); scl = 1'b1; w(2); sda_m = 1'b0; w(2); scl = 1'b0; w(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(2); scl = 1'b1; w(2); sda_m = 1'b1; w(3);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; w(2); scl = 1'b1; w(4); scl = 1'b0; w(2);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; w(2); scl = 1'b1; w(2);
    ack = sda_pd;
    w(2); scl = 1'b0; w(2);
  endtask

  initial begin
    logic a, a2;
    w(3); rst_n = 1'b1; w(1);
    chk("R2 reset value", rdata, 16'h0204);
    chk("R9 flag after reset", flag, 0);
    chk("R10 irq after reset", irq, 0);
    chk("R7 pd after reset", sda_pd, 0);
    reg_wr(16'hFFFF); chk("R1 reserved bits read zero", rdata, 16'h03FF);
    reg_wr(16'hFC00); chk("R1 reserved write ignored", rdata, 16'h0000);
    reg_wr(16'h02A5); chk("R1 low bits stored", rdata, 16'h02A5);

    en = 1'b1;
    // R3 R4 R6 R9 R10: 7-bit sweep, own address, single-bit flips, both directions
    for (int k = 0; k < 8; k++) begin
      logic [6:0] own7;
      own7 = 7'((k * 37 + 5) & 7'h7F);
      irqen = k[0];
      reg_wr({6'd0, 3'(k), own7});
      for (int j = 0; j < 8; j++) begin
        for (int rw = 0; rw < 2; rw++) begin
          logic [6:0] s7;
          int hit;
          s7 = (j == 0) ? own7 : (own7 ^ 7'(1 << (j - 1)));
          hit = (j == 0) ? 1 : 0;
          prep(); bus_start(); send_byte({s7, 1'(rw)}, a);
          chk(hit ? "R3 7-bit ack" : "R6 7-bit no ack", a, hit);
          chk("R9 flag", flag, hit);
          chk("R9 master cleared", mst, 1 - hit);
          chk("R10 irq", irq, hit & k[0]);
          bus_stop();
        end
      end
    end
    irqen = 1'b1;

    // R4: bits 9:7 differ from anything in the byte, still matched
    reg_wr(16'h0380 | 16'h0012);
    prep(); bus_start(); send_byte(8'h24, a); bus_stop();
    chk("R4 upper bits ignored in 7-bit", a, 1);

    // R6: mismatch then matching byte without START, then repeated START
    reg_wr(16'h0012);
    prep(); bus_start(); send_byte(8'h26, a);
    chk("R6 mismatch ack", a, 0);
    send_byte(8'h24, a);
    chk("R6 ignored until START", a, 0);
    chk("R6 flag stays clear", flag, 0);
    bus_start(); send_byte(8'h24, a);
    chk("R6 match after repeated START", a, 1);
    bus_stop();

    // R9: flag holds over non-matching traffic until cleared
    bus_start(); send_byte(8'h30, a); bus_stop(); w(5);
    chk("R9 flag held", flag, 1);
    prep();
    chk("R9 flag cleared", flag, 0);

    // R11: STOP mid-address, then a full byte with no START
    bus_start(); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); bus_stop();
    scl = 1'b0; w(2);
    send_byte(8'h24, a);
    chk("R11 no ack after STOP", a, 0);
    chk("R11 flag", flag, 0);
    scl = 1'b1; sda_m = 1'b1; w(3);

    // R8: NACK level from ack_val
    ackv = 1'b1; prep(); bus_start(); send_byte(8'h24, a); bus_stop();
    chk("R8 released on match", a, 0);
    chk("R8 flag set", flag, 1);
    ackv = 1'b0;

    // R7: disabled
    en = 1'b0; prep(); bus_start(); send_byte(8'h24, a); bus_stop();
    chk("R7 no ack when disabled", a, 0);
    chk("R7 no flag when disabled", flag, 0);
    en = 1'b1;

    // R5: 10-bit sweep
    ten = 1'b1;
    for (int k = 0; k < 6; k++) begin
      logic [9:0] own10;
      own10 = 10'((k * 181 + 16'h2A5) & 16'h3FF);
      reg_wr({6'd0, own10});
      for (int t = 0; t < 4; t++) begin
        logic [7:0] b1, b2;
        int e1, e2;
        b1 = {5'b11110, own10[9:8], 1'(k & 1)};
        b2 = own10[7:0];
        if (t == 1) b1[1] = ~b1[1];
        if (t == 2) b2[k] = ~b2[k];
        if (t == 3) b1[7:3] = 5'b11100;
        e1 = (t == 0 || t == 2) ? 1 : 0;
        e2 = (t == 0) ? 1 : 0;
        prep(); bus_start(); send_byte(b1, a);
        chk("R5 first byte ack", a, e1);
        chk("R5 no flag after first byte", flag, 0);
        send_byte(b2, a2);
        chk("R5 second byte ack", a2, e2);
        chk("R5 flag after second byte", flag, e2);
        bus_stop();
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule